// File: doc/BRIEF.md
# Receive Character Retiming Buffer

This block sits behind an FSK demodulator that produces a raw logic-level receive stream at 1200 bit/s. It finds each asynchronous character, samples the nine bits that follow the start bit at their centres, and parks them in a holding register. A host that has no UART then pulls the bits out one at a time with slow, loosely timed strobes on its CLK line. An active-low ready flag tells the host that a character is waiting.

The host chooses the mode on each character through the level of its strobe line. If the strobe is low when a character completes, the block enters the handshake and the receive output pin shows the held bits. If the strobe is high, the block stays in bypass: the output pin copies the raw demodulated stream and ready never asserts. A strobe line held high all the time therefore turns retiming off entirely.

While receive mode is disabled, which includes the zero-power state, the output pin is held low. Any character that is partly captured or partly transferred is dropped.

Top module: `rx_retime_buf`

## Requirements
- R1: After reset, `rdy_n` is 1 and `rxd` is 0. Once `rx_en` is 1 with no character pending, `rxd` follows `raw_bit` with a latency of two clocks.
- R2: A character starts on a 1-to-0 transition of `raw_bit`. The line is checked again half a bit period (`BIT_DIV/2` clocks) later, and a low pulse shorter than that is ignored. Nine bits are then sampled at their centres, one per `BIT_DIV` clocks, and the first bit received is the first bit presented.
- R3: If the synchronised host strobe is low when the ninth bit is captured, `rdy_n` goes to 0 and `rxd` shows the first captured bit.
- R4: `rdy_n` returns to 1 on the first rising edge of the host strobe after it asserted.
- R5: Each of the first eight falling edges of the host strobe moves the next captured bit onto `rxd`, in order of reception (bits 2 through 9).
- R6: After the ninth falling edge of the strobe, `rxd` again follows `raw_bit`.
- R7: If the host strobe is high when a character completes, `rdy_n` stays 1 and `rxd` keeps following `raw_bit`.
- R8: While `rx_en` is 0, `rxd` is 0 and `rdy_n` is 1 from the next clock on. Any character in progress is dropped and does not raise ready later.
- R9: If a new character completes while the host is still shifting out the previous one, the holding register is overwritten and the handshake starts again from the new first bit.
- R10: After a character is captured, the next start bit is accepted only after the line has first returned high. A line that stays low never yields a further character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (one bit period = `BIT_DIV` cycles) |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive mode enable; 0 = receiver off or zero-power |
| raw_bit | input | 1 | Raw demodulated receive data |
| host_clk | input | 1 | Host strobe line (asynchronous) |
| rxd | output | 1 | Receive data pin: raw stream or retimed bit |
| rdy_n | output | 1 | Active-low character-ready flag |

## Verification
The bench builds the block with `BIT_DIV = 16`, so that one bit lasts 16 clocks. With that value a full character, a stuck-low line held for twenty bit times, and an overwrite in the middle of a transfer all fit into a few thousand cycles. The half-bit start check then takes 8 clocks, which lets a 3-clock glitch fall well short of it. Strobe phases of 8 clocks are long against the synchroniser and the output register, and short enough that nine pulses finish within one character time.

// File: rtl/rxrt_pkg.sv
package rxrt_pkg;
  // character hunter states
  typedef enum logic [1:0] {
    HUNT_MARK  = 2'd0,  // wait for line high (stop / idle)
    HUNT_EDGE  = 2'd1,  // wait for high-to-low transition
    START_CHK  = 2'd2,  // half-bit confirmation of start bit
    DATA_BITS  = 2'd3   // centre-sample the captured bits
  } hunt_e;
endpackage

// File: rtl/rxrt_sync.sv
module rxrt_sync #(
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RST_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/rxrt_framer.sv
module rxrt_framer
  import rxrt_pkg::*;
#(
  parameter int BIT_DIV = 2983,
  parameter int NBITS   = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             raw_bit,
  output logic             line_q,
  output logic             done,
  output logic [NBITS-1:0] word
);
  localparam int CW     = $clog2(BIT_DIV);
  localparam int IW     = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int HALF   = BIT_DIV / 2;
  localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
  localparam logic [CW-1:0] BIT_END  = CW'(BIT_DIV - 1);
  localparam logic [IW-1:0] IDX_END  = IW'(NBITS - 1);

  hunt_e            state;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic [NBITS-1:0] sh;
  logic             line_p;
  logic             done_q;

  // line register and its previous value for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b1;
      line_p <= 1'b1;
    end else begin
      line_q <= raw_bit;
      line_p <= line_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state  <= HUNT_MARK;
      cnt    <= '0;
      idx    <= '0;
      done_q <= 1'b0;
      sh     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        HUNT_MARK: begin
          if (line_q) state <= HUNT_EDGE;
        end
        HUNT_EDGE: begin
          if (line_p && !line_q) begin
            state <= START_CHK;
            cnt   <= '0;
          end
        end
        START_CHK: begin
          if (cnt == HALF_END) begin
            cnt <= '0;
            idx <= '0;
            state <= line_q ? HUNT_MARK : DATA_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        DATA_BITS: begin
          if (cnt == BIT_END) begin
            cnt <= '0;
            sh  <= {line_q, sh[NBITS-1:1]};
            if (idx == IDX_END) begin
              done_q <= 1'b1;
              state  <= HUNT_MARK;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= HUNT_MARK;
      endcase
    end
  end

  assign done = done_q;
  assign word = sh;
endmodule

// File: rtl/rxrt_hand.sv
module rxrt_hand #(
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             host_s,
  input  logic             done,
  input  logic [NBITS-1:0] word,
  input  logic             line_q,
  output logic             rxd,
  output logic             rdy_n
);
  localparam int FW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [FW-1:0] FALL_END = FW'(NBITS - 1);

  logic             host_p;
  logic             act, act_n;
  logic [NBITS-1:0] hold, hold_n;
  logic [FW-1:0]    fcnt, fcnt_n;
  logic             rdy_q, rdy_nx;
  logic             rxd_q, rxd_nx;
  logic             rise, fall;

  assign rise = host_s & ~host_p;
  assign fall = ~host_s & host_p;

  always_comb begin
    act_n  = act;
    hold_n = hold;
    fcnt_n = fcnt;
    rdy_nx = rdy_q;
    if (!en) begin
      act_n  = 1'b0;
      rdy_nx = 1'b1;
    end else if (done) begin
      if (!host_s) begin
        act_n  = 1'b1;
        hold_n = word;
        fcnt_n = '0;
        rdy_nx = 1'b0;
      end else begin
        act_n  = 1'b0;
        rdy_nx = 1'b1;
      end
    end else if (act) begin
      if (rise) rdy_nx = 1'b1;
      if (fall) begin
        if (fcnt == FALL_END) begin
          act_n = 1'b0;
        end else begin
          hold_n = hold >> 1;
          fcnt_n = fcnt + 1'b1;
        end
      end
    end
    rxd_nx = !en ? 1'b0 : (act_n ? hold_n[0] : line_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_p <= 1'b1;
      act    <= 1'b0;
      hold   <= '0;
      fcnt   <= '0;
      rdy_q  <= 1'b1;
      rxd_q  <= 1'b0;
    end else begin
      host_p <= host_s;
      act    <= act_n;
      hold   <= hold_n;
      fcnt   <= fcnt_n;
      rdy_q  <= rdy_nx;
      rxd_q  <= rxd_nx;
    end
  end

  assign rxd   = rxd_q;
  assign rdy_n = rdy_q;
endmodule

// File: rtl/rx_retime_buf.sv
module rx_retime_buf #(
  parameter int BIT_DIV     = 2983,
  parameter int NBITS       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_en,
  input  logic raw_bit,
  input  logic host_clk,
  output logic rxd,
  output logic rdy_n
);
  logic             host_s;
  logic             line_q;
  logic             done;
  logic [NBITS-1:0] word;

  rxrt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk   (clk),
    .rst   (rst),
    .d_in  (host_clk),
    .q_out (host_s)
  );

  rxrt_framer #(.BIT_DIV(BIT_DIV), .NBITS(NBITS)) framer_i (
    .clk     (clk),
    .rst     (rst),
    .en      (rx_en),
    .raw_bit (raw_bit),
    .line_q  (line_q),
    .done    (done),
    .word    (word)
  );

  rxrt_hand #(.NBITS(NBITS)) hand_i (
    .clk    (clk),
    .rst    (rst),
    .en     (rx_en),
    .host_s (host_s),
    .done   (done),
    .word   (word),
    .line_q (line_q),
    .rxd    (rxd),
    .rdy_n  (rdy_n)
  );
endmodule

// File: rtl/rxrt_chk.sv
module rxrt_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic raw_bit,
  input logic host_clk,
  input logic rxd,
  input logic rdy_n
);
  // R8: disabled receiver keeps the pins quiet
  a_r8_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!rxd && rdy_n));

  // R8: ready can only be low if receive was enabled on the previous edge
  a_r8_rdy_needs_en: assert property (@(posedge clk) disable iff (rst)
    !rdy_n |-> $past(rx_en));

  // R4: a strobe held high long enough always leaves ready released
  a_r4_rdy_released: assert property (@(posedge clk) disable iff (rst)
    (host_clk && $past(host_clk) && $past(host_clk, 2) &&
     $past(host_clk, 3) && $past(host_clk, 4)) |-> rdy_n);

  // R7: ready only asserts when the strobe was low at the transfer
  a_r7_bypass_no_rdy: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n) |-> !$past(host_clk, 3));

  logic unused_raw;
  assign unused_raw = raw_bit;
endmodule

bind rx_retime_buf rxrt_chk chk_i (.*);

// File: tb/rx_retime_buf_tb_top.sv
module rx_retime_buf_tb_top;
  localparam int BD = 16;

  logic clk = 1'b0;
  logic rst, rx_en, raw_bit, host_clk;
  logic rxd, rdy_n;

  int checks = 0;
  int fails  = 0;
  logic exp_q[$];
  bit watch = 1'b0;
  bit seen_low = 1'b0;

  always #5 clk = ~clk;

  rx_retime_buf #(.BIT_DIV(BD), .NBITS(9), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .raw_bit(raw_bit),
    .host_clk(host_clk), .rxd(rxd), .rdy_n(rdy_n)
  );

  always @(negedge clk) if (watch && !rdy_n) seen_low = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: sends start, nine bits, two stop periods; pushes expected bits
  task automatic send_char(input logic [8:0] b, input logic stop_lvl,
                           input bit expect_q, input bit follow);
    logic v;
    if (expect_q) for (int i = 0; i < 9; i++) exp_q.push_back(b[i]);
    for (int k = 0; k < 12; k++) begin
      v = (k == 0) ? 1'b0 : (k <= 9) ? b[k-1] : stop_lvl;
      raw_bit = v;
      tick(BD / 2);
      if (follow) chk(rxd == v, "R7 follow", rxd, v);
      tick(BD - BD / 2);
    end
  endtask

  // monitor side: pops expected bits and compares them as the host strobes
  task automatic drain(input int npulses, input string tag);
    logic e;
    chk(rdy_n == 1'b0, {tag, " ready low"}, rdy_n, 0);
    e = exp_q.pop_front();
    chk(rxd == e, {tag, " first bit"}, rxd, e);
    for (int k = 0; k < npulses; k++) begin
      host_clk = 1'b1;
      tick(8);
      if (k == 0) chk(rdy_n == 1'b1, "R4 ready release", rdy_n, 1);
      host_clk = 1'b0;
      tick(8);
      if (k < 8) begin
        e = exp_q.pop_front();
        chk(rxd == e, "R5 shifted bit", rxd, e);
      end else begin
        chk(rxd == raw_bit, "R6 raw reconnect", rxd, raw_bit);
        chk(rdy_n == 1'b1, "R6 ready idle", rdy_n, 1);
      end
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst = 1'b1; rx_en = 1'b0; raw_bit = 1'b1; host_clk = 1'b1;
    tick(5);
    chk(rdy_n == 1'b1, "R1 reset rdy_n", rdy_n, 1);
    chk(rxd == 1'b0, "R1 reset rxd", rxd, 0);
    rst = 1'b0;
    tick(3);
    chk(rxd == 1'b0, "R8 disabled rxd", rxd, 0);
    rx_en = 1'b1;
    tick(3);
    chk(rxd == 1'b1, "R1 idle follow", rxd, 1);

    // bypass with strobe held high
    watch = 1'b1; seen_low = 1'b0;
    send_char(9'h0A5, 1'b1, 1'b0, 1'b1);
    chk(seen_low == 1'b0, "R7 no ready", seen_low, 0);
    watch = 1'b0;

    // retimed characters, several patterns
    host_clk = 1'b0;
    tick(4);
    send_char(9'h1B3, 1'b1, 1'b1, 1'b0);
    drain(9, "R3");
    send_char(9'h100, 1'b1, 1'b1, 1'b0);
    drain(9, "R2");
    send_char(9'h0FE, 1'b1, 1'b1, 1'b0);
    drain(9, "R3");

    // short low glitch is no start bit
    watch = 1'b1; seen_low = 1'b0;
    raw_bit = 1'b0; tick(3); raw_bit = 1'b1; tick(40);
    chk(seen_low == 1'b0, "R2 glitch rejected", seen_low, 0);
    watch = 1'b0;
    send_char(9'h03C, 1'b1, 1'b1, 1'b0);
    drain(9, "R2");

    // overwrite during transfer
    send_char(9'h0C9, 1'b1, 1'b1, 1'b0);
    drain(3, "R3");
    exp_q.delete();
    send_char(9'h136, 1'b1, 1'b1, 1'b0);
    drain(9, "R9");

    // line stuck low after a character: no new start
    host_clk = 1'b1;
    tick(8);
    send_char(9'h000, 1'b0, 1'b0, 1'b0);
    host_clk = 1'b0;
    watch = 1'b1; seen_low = 1'b0;
    tick(BD * 20);
    chk(seen_low == 1'b0, "R10 no restart on low line", seen_low, 0);
    watch = 1'b0;
    raw_bit = 1'b1;
    tick(BD * 2);
    send_char(9'h1C7, 1'b1, 1'b1, 1'b0);
    drain(9, "R10");

    // disable while ready is pending
    send_char(9'h0AA, 1'b1, 1'b1, 1'b0);
    chk(rdy_n == 1'b0, "R3 pending", rdy_n, 0);
    rx_en = 1'b0;
    tick(3);
    chk(rdy_n == 1'b1, "R8 ready dropped", rdy_n, 1);
    chk(rxd == 1'b0, "R8 rxd low", rxd, 0);
    exp_q.delete();
    rx_en = 1'b1;
    tick(3);
    chk(rxd == 1'b1, "R8 follow after enable", rxd, 1);

    // disable in the middle of a character
    raw_bit = 1'b0;
    tick(BD * 3);
    rx_en = 1'b0;
    tick(BD * 3);
    raw_bit = 1'b1;
    rx_en = 1'b1;
    watch = 1'b1; seen_low = 1'b0;
    tick(BD * 12);
    chk(seen_low == 1'b0, "R8 partial character dropped", seen_low, 0);
    watch = 1'b0;

    finish_run();
  end
endmodule